// File: doc/BRIEF.md
# Pseudo-SRAM Refresh Controller

This block generates all refresh activity for a pseudo-SRAM attached to a bus controller. A prescaler divides the bus clock by a selectable ratio and advances an interval counter. When the counter reaches the compare value, a refresh request is raised and the counter restarts from zero. A sequencer turns each request into one auto-refresh cycle: it pulls the active-low refresh strobe for a programmed number of states, then keeps chip enable blocked for a programmed precharge time.

Software drives the block through a small synchronous write port. One enable/mode bit pair selects the behaviour. With the pair at enable only, the block runs periodic auto-refresh. With both bits set, it holds the strobe low for self-refresh and blocks every access. Clearing either bit releases self-refresh. After release, a fixed recovery time must pass before any auto-refresh cycle may start. A request never interrupts a memory access that is in progress. While a request is pending or a refresh is running, the busy output tells the access arbiter to hold off new accesses.

Top module: `psram_refresh_ctrl`

## Requirements
- R1: Register port (write when `wr_en` is 1 on a rising clock edge). Address 0 is control: bit0 = refresh enable, bit1 = self mode, bits3:2 = strobe state count, bits5:4 = extra strobe wait states, bits7:6 = precharge count. Address 1 is the prescaler select (bits2:0). Address 2 is the interval counter. Address 3 is the compare value. All registers reset to 0. In reset, `rfsh_n`=1, `ce_allow`=1 and `busy`=0, and no refresh occurs until the registers are written.
- R2: Select values 1..7 divide the clock by 4, 16, 64, 256, 1024, 2048 and 4096. Select 0 stops the prescaler, and the interval counter then holds its value. Writing the select register restarts the prescaler from zero.
- R3: With enable=1 and mode=0, a prescaler tick that would carry the counter onto the compare value raises a request and clears the counter instead. Auto-refresh strobes therefore begin every ratio × compare clock cycles (a compare of 0 means 2^CNT_W).
- R4: A write to address 2 loads the counter directly. After loading N and then writing the select register, the first strobe falls ratio × (compare − N) + 1 cycles after the select write.
- R5: During an auto-refresh cycle, `rfsh_n` is low for (strobe count + extra wait states + 1) consecutive cycles, and `ce_allow` is low throughout.
- R6: After `rfsh_n` rises at the end of an auto-refresh cycle, `ce_allow` stays low for (precharge count + 1) more cycles while `rfsh_n` stays high.
- R7: A pending request does not start while `acc_active` is 1, and `busy` is 1 during that wait. The strobe falls in the cycle after `acc_active` returns to 0.
- R8: With enable=1 and mode=1, once no access is active, `rfsh_n` goes low and stays low. `ce_allow` is 0 and `busy` is 1 for the whole of self-refresh.
- R9: Clearing either the mode bit or the enable bit ends self-refresh. `rfsh_n` is high one cycle after the write.
- R10: After self-refresh ends, RECOV_CYCLES cycles pass with `rfsh_n` high and `busy` 0. A request that matures during this time is held. The held request then starts its strobe RECOV_CYCLES + 1 cycles after `rfsh_n` rose.
- R11: With enable=0, no auto-refresh starts, and any pending request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | CNT_W | Register write data |
| acc_active | input | 1 | A normal memory access is in progress |
| rfsh_n | output | 1 | Active-low refresh strobe to the pseudo-SRAM |
| ce_allow | output | 1 | Chip enable may be asserted when 1 |
| busy | output | 1 | Tells the arbiter to hold off new accesses |

## Verification
Every cycle, the assertions check that a low strobe always blocks chip enable. They check that no strobe falls in a cycle that follows an active access, and that a stopped prescaler freezes the counter. They also check that an auto strobe ends in precharge with chip enable still blocked, that self-refresh holds the strobe low with busy set, that recovery keeps the strobe high, and that an auto strobe never runs past seven cycles. Only the bench scenarios can show the exact interval arithmetic for every divide ratio, the exact strobe and precharge widths for each field setting, the latency after a counter load, and the exact start cycle after recovery.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int PRE_W = 12;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_SEL  = 2'd1,
    ADDR_CNT  = 2'd2,
    ADDR_CMP  = 2'd3
  } reg_addr_e;

  // control register, MSB first: precharge, extra wait, strobe count, mode, enable
  typedef struct packed {
    logic [1:0] pre;
    logic [1:0] wt;
    logic [1:0] ast;
    logic       mode;
    logic       en;
  } ctrl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_STROBE,
    S_PRECH,
    S_SELF,
    S_RECOV
  } seq_state_e;

  // terminal value of the prescaler for a select code (ratio - 1)
  function automatic logic [PRE_W-1:0] div_limit(input logic [2:0] sel);
    logic [PRE_W-1:0] lim;
    case (sel)
      3'd1:    lim = PRE_W'(3);
      3'd2:    lim = PRE_W'(15);
      3'd3:    lim = PRE_W'(63);
      3'd4:    lim = PRE_W'(255);
      3'd5:    lim = PRE_W'(1023);
      3'd6:    lim = PRE_W'(2047);
      3'd7:    lim = PRE_W'(4095);
      default: lim = '0;
    endcase
    return lim;
  endfunction

  // strobe low length minus one
  function automatic logic [2:0] strobe_len_m1(input ctrl_t c);
    return {1'b0, c.ast} + {1'b0, c.wt};
  endfunction

endpackage

// File: rtl/psr_regs.sv
module psr_regs
  import psr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output ctrl_t            ctrl,
  output logic [2:0]       sel,
  output logic             sel_wr,
  output logic [CNT_W-1:0] cmp,
  output logic             cnt_wr,
  output logic [CNT_W-1:0] cnt_wdata
);

  logic ctrl_wr, cmp_wr;

  assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
  assign sel_wr    = wr_en && (wr_addr == ADDR_SEL);
  assign cnt_wr    = wr_en && (wr_addr == ADDR_CNT);
  assign cmp_wr    = wr_en && (wr_addr == ADDR_CMP);
  assign cnt_wdata = wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      sel  <= '0;
      cmp  <= '0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_t'(wr_data[7:0]);
      if (sel_wr)  sel  <= wr_data[2:0];
      if (cmp_wr)  cmp  <= wr_data;
    end
  end

endmodule

// File: rtl/psr_interval.sv
module psr_interval
  import psr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sel,
  input  logic             sel_wr,
  input  logic [CNT_W-1:0] cmp,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             tick,
  output logic             req_pulse,
  output logic [CNT_W-1:0] cnt_q
);

  logic [PRE_W-1:0] pcnt_q;
  logic [CNT_W-1:0] cnt_next;

  assign tick      = (sel != 3'd0) && (pcnt_q == div_limit(sel));
  assign cnt_next  = cnt_q + 1'b1;
  assign req_pulse = tick && (cnt_next == cmp) && !cnt_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (sel_wr || sel == 3'd0 || tick) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      cnt_q <= cnt_wdata;
    end else if (req_pulse) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_next;
    end
  end

endmodule

// File: rtl/psr_sequencer.sv
module psr_sequencer
  import psr_pkg::*;
#(
  parameter int RECOV_CYCLES = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl,
  input  logic  req_pulse,
  input  logic  acc_active,
  output logic  rfsh_n,
  output logic  ce_allow,
  output logic  busy,
  output logic  pending,
  output logic  launch,
  output logic  strobe_active,
  output logic  prech_active,
  output logic  self_active,
  output logic  recov_active
);

  localparam int TMR_W = $clog2(RECOV_CYCLES + 8);
  localparam logic [TMR_W-1:0] RECOV_LOAD = TMR_W'(RECOV_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             self_req, auto_en, enter_self, tmr_zero;

  assign self_req   = ctrl.en && ctrl.mode;
  assign auto_en    = ctrl.en && !ctrl.mode;
  assign tmr_zero   = (tmr_q == '0);
  assign launch     = (state_q == S_IDLE) && !self_req && pending && !acc_active;
  assign enter_self = (state_q == S_IDLE) && self_req && !acc_active;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    unique case (state_q)
      S_IDLE: begin
        if (enter_self) begin
          state_d = S_SELF;
        end else if (launch) begin
          state_d = S_STROBE;
          tmr_d   = TMR_W'(strobe_len_m1(ctrl));
        end
      end
      S_STROBE: begin
        if (tmr_zero) begin
          state_d = S_PRECH;
          tmr_d   = TMR_W'(ctrl.pre);
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      S_PRECH: begin
        if (tmr_zero) state_d = S_IDLE;
        else          tmr_d   = tmr_q - 1'b1;
      end
      S_SELF: begin
        if (!self_req) begin
          state_d = S_RECOV;
          tmr_d   = RECOV_LOAD;
        end
      end
      S_RECOV: begin
        if (tmr_zero) state_d = S_IDLE;
        else          tmr_d   = tmr_q - 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tmr_q   <= '0;
      pending <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      pending <= auto_en && ((pending && !launch) || req_pulse);
    end
  end

  assign strobe_active = (state_q == S_STROBE);
  assign prech_active  = (state_q == S_PRECH);
  assign self_active   = (state_q == S_SELF);
  assign recov_active  = (state_q == S_RECOV);

  assign rfsh_n   = !(strobe_active || self_active);
  assign ce_allow = !(strobe_active || prech_active || self_active);
  assign busy     = strobe_active || prech_active || self_active ||
                    (pending && !recov_active);

endmodule

// File: rtl/psram_refresh_ctrl.sv
module psram_refresh_ctrl
  import psr_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int RECOV_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             acc_active,
  output logic             rfsh_n,
  output logic             ce_allow,
  output logic             busy
);

  ctrl_t            ctrl;
  logic [2:0]       sel;
  logic             sel_wr, cnt_wr;
  logic [CNT_W-1:0] cmp, cnt_wdata, cnt_q;
  logic             tick, req_pulse;
  logic             pending, launch;
  logic             strobe_active, prech_active, self_active, recov_active;

  psr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ctrl      (ctrl),
    .sel       (sel),
    .sel_wr    (sel_wr),
    .cmp       (cmp),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata)
  );

  psr_interval #(.CNT_W(CNT_W)) u_interval (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .sel_wr    (sel_wr),
    .cmp       (cmp),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .tick      (tick),
    .req_pulse (req_pulse),
    .cnt_q     (cnt_q)
  );

  psr_sequencer #(.RECOV_CYCLES(RECOV_CYCLES)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl          (ctrl),
    .req_pulse     (req_pulse),
    .acc_active    (acc_active),
    .rfsh_n        (rfsh_n),
    .ce_allow      (ce_allow),
    .busy          (busy),
    .pending       (pending),
    .launch        (launch),
    .strobe_active (strobe_active),
    .prech_active  (prech_active),
    .self_active   (self_active),
    .recov_active  (recov_active)
  );

endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_active,
  input logic             rfsh_n,
  input logic             ce_allow,
  input logic             busy,
  input logic [2:0]       sel,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_q,
  input logic             strobe_active,
  input logic             self_active,
  input logic             recov_active
);

  logic [3:0] strobe_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                          strobe_run <= '0;
    else if (!strobe_active)             strobe_run <= '0;
    else if (strobe_run != 4'hF)         strobe_run <= strobe_run + 1'b1;
  end

  assert_low_blocks_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> !ce_allow);

  assert_strobe_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_active |-> (strobe_run < 4'd7));

  assert_no_start_in_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rfsh_n) |-> !$past(acc_active));

  assert_stopped_counter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 && !cnt_wr) |=> $stable(cnt_q));

  assert_precharge_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rfsh_n) && !recov_active) |-> !ce_allow);

  assert_self_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    self_active |-> (!rfsh_n && busy));

  assert_recovery_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    recov_active |-> (rfsh_n && !busy));

endmodule

bind psram_refresh_ctrl psr_checker #(.CNT_W(CNT_W)) u_psr_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_active    (acc_active),
  .rfsh_n        (rfsh_n),
  .ce_allow      (ce_allow),
  .busy          (busy),
  .sel           (sel),
  .cnt_wr        (cnt_wr),
  .cnt_q         (cnt_q),
  .strobe_active (strobe_active),
  .self_active   (self_active),
  .recov_active  (recov_active)
);

// File: tb/test_psram_refresh_ctrl.sv
module test_psram_refresh_ctrl;

  localparam int CNT_W = 8;
  localparam int RECOV = 6;
  localparam logic [1:0] A_CTRL = 2'd0, A_SEL = 2'd1, A_CNT = 2'd2, A_CMP = 2'd3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             acc_active = 1'b0;
  logic             rfsh_n, ce_allow, busy;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  psram_refresh_ctrl #(.CNT_W(CNT_W), .RECOV_CYCLES(RECOV)) i_psram_refresh_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .acc_active (acc_active),
    .rfsh_n     (rfsh_n),
    .ce_allow   (ce_allow),
    .busy       (busy)
  );

  // divide ratio restated: 4^s for s<=4, then 2^(s+5)
  function automatic int ratio(input int s);
    if (s == 0) return 0;
    if (s <= 4) return 1 << (2 * s);
    return 1 << (s + 5);
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // returns the edge index at which the write took effect
  task automatic wr(input logic [1:0] a, input int d, output int at);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
    at = cyc;
  endtask

  task automatic wait_low(output int at);
    do @(negedge clk); while (rfsh_n !== 1'b0);
    at = cyc;
  endtask

  task automatic wait_fall(output int at);
    @(negedge clk);
    while (rfsh_n === 1'b0) @(negedge clk);
    while (rfsh_n === 1'b1) @(negedge clk);
    at = cyc;
  endtask

  always @(posedge clk) begin
    if (cyc > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int t, t1, t2, t3, n, lo_len, pr_len, ok;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and no activity without programming
    check_eq("R1 rfsh_n after reset", rfsh_n, 1);
    check_eq("R1 ce_allow after reset", ce_allow, 1);
    check_eq("R1 busy after reset", busy, 0);
    n = 0;
    repeat (60) begin @(negedge clk); if (!rfsh_n) n++; end
    check_eq("R1 no strobe while unprogrammed", n, 0);

    // R5 / R6: sweep all strobe and precharge field settings
    wr(A_CMP, 4, t);
    wr(A_CNT, 0, t);
    wr(A_CTRL, 1, t);
    wr(A_SEL, 1, t);
    for (int ast = 0; ast < 4; ast++) begin
      for (int wt = 0; wt < 4; wt++) begin
        for (int pr = 0; pr < 4; pr++) begin
          wr(A_CTRL, (pr << 6) | (wt << 4) | (ast << 2) | 1, t);
          wait_fall(t1);
          lo_len = 0;
          while (rfsh_n === 1'b0) begin lo_len++; @(negedge clk); end
          pr_len = 0;
          while (rfsh_n === 1'b1 && ce_allow === 1'b0) begin pr_len++; @(negedge clk); end
          check_eq("R5 strobe width", lo_len, ast + wt + 1);
          check_eq("R6 precharge width", pr_len, pr + 1);
        end
      end
    end

    // R2 / R3: every divide ratio, two compare values
    wr(A_CTRL, 1, t);
    for (int s = 1; s < 8; s++) begin
      for (int c = 1; c < 3; c++) begin
        wr(A_CMP, c, t);
        wr(A_SEL, s, t);
        wait_fall(t1);
        wait_fall(t2);
        wait_fall(t3);
        check_eq("R2 R3 refresh period", t3 - t2, ratio(s) * c);
      end
    end

    // R2: select 0 stops; R4: counter load latency
    wr(A_SEL, 0, t);
    repeat (20) @(negedge clk);
    wr(A_CMP, 10, t);
    wr(A_CNT, 7, t);
    n = 0;
    repeat (100) begin @(negedge clk); if (!rfsh_n) n++; end
    check_eq("R2 stopped prescaler gives no strobe", n, 0);
    wr(A_SEL, 1, t);
    wait_low(t1);
    check_eq("R4 first strobe after load 7", t1 - t, 4 * (10 - 7) + 1);
    wait_fall(t2);
    check_eq("R3 period after counter clear", t2 - t1, 40);
    wr(A_SEL, 0, t);
    repeat (20) @(negedge clk);
    wr(A_CNT, 0, t);
    wr(A_CMP, 3, t);
    wr(A_SEL, 2, t);
    wait_low(t1);
    check_eq("R4 first strobe after load 0 div16", t1 - t, 16 * 3 + 1);

    // R7: request waits for the access to end
    wr(A_SEL, 0, t);
    repeat (20) @(negedge clk);
    wr(A_CNT, 0, t);
    wr(A_CMP, 5, t);
    @(negedge clk);
    acc_active = 1'b1;
    wr(A_SEL, 1, t);
    ok = 1;
    while (cyc < t + 30) begin
      @(negedge clk);
      if (rfsh_n !== 1'b1) ok = 0;
    end
    check_eq("R7 no strobe during access", ok, 1);
    check_eq("R7 busy while request waits", busy, 1);
    check_eq("R7 ce_allow while request waits", ce_allow, 1);
    acc_active = 1'b0;
    @(negedge clk);
    check_eq("R7 strobe low after access ends", rfsh_n, 0);
    check_eq("R7 strobe start cycle", cyc - t, 31);

    // R8 / R9 / R10: self-refresh via mode bit, exit via mode bit
    wr(A_SEL, 0, t);
    repeat (20) @(negedge clk);
    wr(A_CMP, 1, t);
    wr(A_CNT, 0, t);
    wr(A_SEL, 1, t);
    @(negedge clk);
    acc_active = 1'b1;
    repeat (20) @(negedge clk);
    wr(A_CTRL, 3, t);
    ok = 1;
    repeat (10) begin @(negedge clk); if (rfsh_n !== 1'b1) ok = 0; end
    check_eq("R8 self entry waits for access", ok, 1);
    acc_active = 1'b0;
    @(negedge clk);
    check_eq("R8 strobe low in self-refresh", rfsh_n, 0);
    check_eq("R8 ce_allow in self-refresh", ce_allow, 0);
    check_eq("R8 busy in self-refresh", busy, 1);
    n = 0;
    repeat (200) begin @(negedge clk); if (rfsh_n) n++; end
    check_eq("R8 strobe held low", n, 0);
    wr(A_CTRL, 1, t);
    @(negedge clk);
    check_eq("R9 strobe high after mode clear", rfsh_n, 1);
    check_eq("R10 busy low in recovery", busy, 0);
    check_eq("R10 ce_allow in recovery", ce_allow, 1);
    wait_low(t1);
    check_eq("R10 held request start after recovery", t1 - (t + 1), RECOV + 1);

    // R9 / R11: exit via enable bit, then nothing
    wr(A_CTRL, 3, t);
    repeat (10) @(negedge clk);
    check_eq("R8 self-refresh re-entered", rfsh_n, 0);
    wr(A_CTRL, 0, t);
    @(negedge clk);
    check_eq("R9 strobe high after enable clear", rfsh_n, 1);
    n = 0;
    repeat (100) begin @(negedge clk); if (!rfsh_n) n++; end
    check_eq("R11 no refresh while disabled", n, 0);
    check_eq("R11 busy low while disabled", busy, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule